// File: doc/BRIEF.md
# USB Host Controller Status and Interrupt Register

This block keeps the status word of a USB 2.0 host controller and turns it into one interrupt request line. It collects single-cycle event pulses from the transfer schedule engine, from the root-hub port logic and from the system bus interface. It also watches the frame index counter to see when the frame list wraps. It owns the run/stop control bit and reports the halted state. When a host bus error is seen, it stops the controller at once.

Software reads the status word at any time. It clears event flags by writing ones to them. Each event flag is masked by an enable bit, and the enabled flags are ORed into a registered interrupt request. The schedule engine, the port state machines, the frame counter and the bus protocol logic are outside this block. They appear here only as plain input signals.

Top module: `hcsts_top`

## Requirements
- R1: After reset the status word reads 16'h1000 (only the halted flag, bit 12, is set), run/stop is 0, the doorbell is not pending and the interrupt request is 0.
- R2: Bits 15:13 and 11:6 of the status word always read 0.
- R3: The halted flag (bit 12) is 0 whenever run/stop is 1. When run/stop is 0, the flag becomes 1 at the first clock edge that samples the engine-idle input high. A software write of 1 to the run bit sets run/stop and clears the halted flag at the same edge.
- R4: A pulse on `async_adv` while the doorbell is pending sets bit 5 and clears the pending doorbell at the same edge. An advance pulse with no doorbell pending changes nothing.
- R5: A parity error, master abort or target abort pulse sets bit 4 and clears run/stop at the same edge. This holds even if software writes run=1 in that cycle.
- R6: Bit 3 is set one edge after a toggle of the frame index bit chosen by the size code: code 0 selects bit 13 (1024 entries), code 1 selects bit 12 (512), and codes 2 and 3 select bit 11 (256). Toggles of the other bits have no effect. The first edge after reset never sets bit 3.
- R7: Bit 2 is set by a change pulse on any port whose owner bit is 0, or by a 0-to-1 transition of any port's force-resume input. A change pulse on a port whose owner bit is 1 is ignored.
- R8: A descriptor completion that has its error flag set sets bit 1. If that completion also has interrupt-on-complete set, bits 1 and 0 set at the same edge.
- R9: Bit 0 is set by a descriptor completion with interrupt-on-complete set, or by a short-packet pulse.
- R10: Bits 5:0 stay set until software writes the status word with a 1 in that bit position. Bits written as 0 are left unchanged, and the halted bit cannot be written.
- R11: If an event and a software clear hit the same bit in the same cycle, the bit stays set.
- R12: The interrupt request is the registered OR of status bits 5:0 ANDed with the matching enable bits. It rises one edge after the status bit sets and falls one edge after the last enabled bit clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Software write strobe for the run bit |
| cmd_run | input | 1 | Run bit value written with `cmd_wr` |
| doorbell_ring | input | 1 | Software rings the async-advance doorbell |
| fl_size | input | 2 | Frame list size code (0:1024, 1:512, 2/3:256) |
| sched_idle | input | 1 | Schedule engine reports it has stopped executing |
| async_adv | input | 1 | Asynchronous schedule advanced (pulse) |
| td_done | input | 1 | Transfer descriptor retired (pulse) |
| td_ioc | input | 1 | Retired descriptor had interrupt-on-complete |
| td_err | input | 1 | Retired descriptor ended in error |
| short_pkt | input | 1 | Short packet received (pulse) |
| port_chg | input | NPORTS | Per-port change pulse |
| port_owner | input | NPORTS | Per-port owner bit (1 = handed to companion) |
| force_resume | input | NPORTS | Per-port force-resume level |
| err_parity | input | 1 | Bus parity error pulse |
| err_mabort | input | 1 | Bus master abort pulse |
| err_tabort | input | 1 | Bus target abort pulse |
| frindex | input | FI_W | Frame index counter value |
| sts_wr | input | 1 | Software write strobe for the status word |
| sts_wdata | input | 16 | Status write data, ones clear bits 5:0 |
| intr_en | input | 6 | Interrupt enables for bits 5:0 |
| sts_rdata | output | 16 | Current status word |
| run_stop | output | 1 | Run/stop control bit |
| doorbell_pend | output | 1 | Doorbell request still pending |
| irq | output | 1 | Combined interrupt request |

## Verification
Each event and each status-word write is sampled at one rising edge. The status bit, run/stop, the halted flag and the consumed doorbell all change at that same edge. The interrupt request follows one edge later, because it is registered from the status bits. The bench changes inputs on the falling edge and holds a pulse for exactly one rising edge. It then samples on the next falling edge for status results, and one more cycle later for the interrupt line. Cases that must cause no change are read back through the status word after the edge that could have changed it.

// File: rtl/hcsts_pkg.sv
// Package: shared bit positions and size codes for the host status block.
// Assumes a 16-bit status word with six sticky event flags in the low bits.
package hcsts_pkg;
    localparam int STS_W    = 16;
    localparam int EVT_N    = 6;
    localparam int B_INT    = 0;
    localparam int B_ERR    = 1;
    localparam int B_PORT   = 2;
    localparam int B_WRAP   = 3;
    localparam int B_HSE    = 4;
    localparam int B_ADV    = 5;
    localparam int B_HALT   = 12;

    typedef enum logic [1:0] {
        FL_1024 = 2'd0,
        FL_512  = 2'd1,
        FL_256  = 2'd2,
        FL_RSVD = 2'd3
    } fl_size_e;
endpackage

// File: rtl/hcsts_event_bit.sv
// Module: one sticky write-one-to-clear status flag.
// Assumes set and clear are single-cycle qualified strobes; set has priority.
module hcsts_event_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // Hold the flag; a set in the same cycle as a clear keeps it high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= 1'b0;
        else if (set_i)
            q_o <= 1'b1;
        else if (clr_i)
            q_o <= 1'b0;
    end

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    assert_w1c_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);
    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/hcsts_frame_wrap.sv
// Module: detects frame list wrap as a toggle of a size-selected index bit.
// Assumes the size code may change at any time; it is applied each cycle
// against a stored copy of the same bit, so a size change alone never fires.
module hcsts_frame_wrap #(
    parameter int FI_W = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FI_W-1:0] frindex,
    input  logic [1:0]      fl_size,
    output logic            wrap_evt
);
    import hcsts_pkg::*;

    localparam int TOP_BIT = FI_W - 1;
    localparam int MID_BIT = FI_W - 2;
    localparam int LOW_BIT = FI_W - 3;

    logic [2:0] prev_q;
    logic [2:0] cur;
    logic       armed_q;
    logic       sel_now;
    logic       sel_prev;

    assign cur = {frindex[TOP_BIT], frindex[MID_BIT], frindex[LOW_BIT]};

    // Pick the watched bit from the current size code.
    always_comb begin
        unique case (fl_size_e'(fl_size))
            FL_1024: begin sel_now = cur[2]; sel_prev = prev_q[2]; end
            FL_512:  begin sel_now = cur[1]; sel_prev = prev_q[1]; end
            default: begin sel_now = cur[0]; sel_prev = prev_q[0]; end
        endcase
    end

    // Capture the three candidate bits and arm after the first sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            prev_q  <= cur;
            armed_q <= 1'b1;
        end
    end

    assign wrap_evt = armed_q && (sel_now != sel_prev);

    assert_wrap_needs_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |-> (cur != prev_q));
endmodule

// File: rtl/hcsts_run_ctrl.sv
// Module: run/stop bit, halted flag and async-advance doorbell.
// Assumes host_err and async_adv are single-cycle pulses and that
// sched_idle is a level from the schedule engine.
module hcsts_run_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic cmd_run,
    input  logic doorbell_ring,
    input  logic async_adv,
    input  logic host_err,
    input  logic sched_idle,
    output logic run_stop,
    output logic halted,
    output logic doorbell_pend,
    output logic adv_evt
);
    logic run_next;

    // Next run/stop value: a bus error forces stop over any software write.
    always_comb begin
        run_next = run_stop;
        if (cmd_wr)
            run_next = cmd_run;
        if (host_err)
            run_next = 1'b0;
    end

    assign adv_evt = async_adv && doorbell_pend;

    // Run/stop register and halted tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_stop <= 1'b0;
            halted   <= 1'b1;
        end else begin
            run_stop <= run_next;
            halted   <= run_next ? 1'b0 : (halted || sched_idle);
        end
    end

    // Doorbell request: consumed by an advance, re-armed by a ring.
    always_ff @(posedge clk) begin
        if (!rst_n)
            doorbell_pend <= 1'b0;
        else
            doorbell_pend <= doorbell_ring || (doorbell_pend && !async_adv);
    end

    assert_halt_low_when_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_stop |-> !halted);
    assert_halt_on_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_stop && !cmd_wr && sched_idle) |=> halted);
    assert_err_stops_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |=> !run_stop);
    assert_adv_consumes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_evt && !doorbell_ring) |=> !doorbell_pend);
endmodule

// File: rtl/hcsts_top.sv
// Module: host controller status word, event collection and interrupt line.
// Assumes all event inputs are single-cycle pulses except port_owner,
// force_resume, sched_idle and frindex, which are levels.
module hcsts_top #(
    parameter int NPORTS = 4,
    parameter int FI_W   = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              cmd_run,
    input  logic              doorbell_ring,
    input  logic [1:0]        fl_size,
    input  logic              sched_idle,
    input  logic              async_adv,
    input  logic              td_done,
    input  logic              td_ioc,
    input  logic              td_err,
    input  logic              short_pkt,
    input  logic [NPORTS-1:0] port_chg,
    input  logic [NPORTS-1:0] port_owner,
    input  logic [NPORTS-1:0] force_resume,
    input  logic              err_parity,
    input  logic              err_mabort,
    input  logic              err_tabort,
    input  logic [FI_W-1:0]   frindex,
    input  logic              sts_wr,
    input  logic [15:0]       sts_wdata,
    input  logic [5:0]        intr_en,
    output logic [15:0]       sts_rdata,
    output logic              run_stop,
    output logic              doorbell_pend,
    output logic              irq
);
    import hcsts_pkg::*;

    logic [EVT_N-1:0]  evt_set;
    logic [EVT_N-1:0]  evt_clr;
    logic [EVT_N-1:0]  evt_q;
    logic [NPORTS-1:0] fr_q;
    logic              host_err;
    logic              adv_evt;
    logic              wrap_evt;
    logic              halted;

    assign host_err = err_parity || err_mabort || err_tabort;

    // Remember force-resume levels to find their rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fr_q <= '0;
        else
            fr_q <= force_resume;
    end

    // Map incoming events onto the six sticky flags.
    always_comb begin
        evt_set         = '0;
        evt_set[B_INT]  = (td_done && td_ioc) || short_pkt;
        evt_set[B_ERR]  = td_done && td_err;
        evt_set[B_PORT] = |(port_chg & ~port_owner) || |(force_resume & ~fr_q);
        evt_set[B_WRAP] = wrap_evt;
        evt_set[B_HSE]  = host_err;
        evt_set[B_ADV]  = adv_evt;
    end

    assign evt_clr = sts_wr ? sts_wdata[EVT_N-1:0] : '0;

    hcsts_run_ctrl u_run (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_wr        (cmd_wr),
        .cmd_run       (cmd_run),
        .doorbell_ring (doorbell_ring),
        .async_adv     (async_adv),
        .host_err      (host_err),
        .sched_idle    (sched_idle),
        .run_stop      (run_stop),
        .halted        (halted),
        .doorbell_pend (doorbell_pend),
        .adv_evt       (adv_evt)
    );

    hcsts_frame_wrap #(.FI_W(FI_W)) u_wrap (
        .clk      (clk),
        .rst_n    (rst_n),
        .frindex  (frindex),
        .fl_size  (fl_size),
        .wrap_evt (wrap_evt)
    );

    for (genvar g = 0; g < EVT_N; g++) begin : g_flag
        hcsts_event_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (evt_set[g]),
            .clr_i (evt_clr[g]),
            .q_o   (evt_q[g])
        );
    end

    // Assemble the readable word; unused positions are tied low.
    always_comb begin
        sts_rdata                = '0;
        sts_rdata[EVT_N-1:0]     = evt_q;
        sts_rdata[B_HALT]        = halted;
    end

    // Registered interrupt request from the enabled flags.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= |(evt_q & intr_en);
    end

    assert_irq_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_q & intr_en)) |=> irq);
    assert_irq_drops_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(evt_q & intr_en)) |=> !irq);
    assert_err_sets_hse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |=> (evt_q[B_HSE] && !run_stop));
    assert_both_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (td_done && td_ioc && td_err) |=> (evt_q[B_INT] && evt_q[B_ERR]));
endmodule

// File: tb/test_hcsts_top.sv
// Directed bench for hcsts_top: one task per scenario, each checking itself.
module test_hcsts_top;
    localparam int NP = 4;
    localparam int FW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_wr = 0, cmd_run = 0, doorbell_ring = 0;
    logic [1:0]    fl_size = 0;
    logic          sched_idle = 1, async_adv = 0;
    logic          td_done = 0, td_ioc = 0, td_err = 0, short_pkt = 0;
    logic [NP-1:0] port_chg = 0, port_owner = 0, force_resume = 0;
    logic          err_parity = 0, err_mabort = 0, err_tabort = 0;
    logic [FW-1:0] frindex = 0;
    logic          sts_wr = 0;
    logic [15:0]   sts_wdata = 0;
    logic [5:0]    intr_en = 0;
    logic [15:0]   sts_rdata;
    logic          run_stop, doorbell_pend, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    hcsts_top #(.NPORTS(NP), .FI_W(FW)) i_hcsts_top (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_run(cmd_run),
        .doorbell_ring(doorbell_ring), .fl_size(fl_size), .sched_idle(sched_idle),
        .async_adv(async_adv), .td_done(td_done), .td_ioc(td_ioc), .td_err(td_err),
        .short_pkt(short_pkt), .port_chg(port_chg), .port_owner(port_owner),
        .force_resume(force_resume), .err_parity(err_parity), .err_mabort(err_mabort),
        .err_tabort(err_tabort), .frindex(frindex), .sts_wr(sts_wr),
        .sts_wdata(sts_wdata), .intr_en(intr_en), .sts_rdata(sts_rdata),
        .run_stop(run_stop), .doorbell_pend(doorbell_pend), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One rising edge, then back to the falling edge for driving and sampling.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        sts_wr = 1; sts_wdata = 16'hFFFF;
        step();
        sts_wr = 0; sts_wdata = 0;
    endtask

    task automatic t_reset_R1();
        rst_n = 0;
        step(); step();
        rst_n = 1;
        chk("R1 status", sts_rdata, 16'h1000);
        chk("R1 run", {15'b0, run_stop}, 16'h0);
        chk("R1 irq/doorbell", {14'b0, irq, doorbell_pend}, 16'h0);
    endtask

    task automatic t_halt_R3();
        cmd_wr = 1; cmd_run = 1;
        step();
        cmd_wr = 0;
        chk("R3 run sets, halted clears", sts_rdata, 16'h0000);
        chk("R3 run", {15'b0, run_stop}, 16'h1);
        sched_idle = 0;
        cmd_wr = 1; cmd_run = 0;
        step();
        cmd_wr = 0;
        chk("R3 stopped, engine busy", sts_rdata, 16'h0000);
        step();
        chk("R3 still busy", sts_rdata, 16'h0000);
        sched_idle = 1;
        step();
        chk("R3 halted after idle", sts_rdata, 16'h1000);
    endtask

    task automatic t_hse_R5();
        cmd_wr = 1; cmd_run = 1;
        step();
        err_mabort = 1;
        step();
        cmd_wr = 0; err_mabort = 0;
        chk("R5 hse bit with run write", sts_rdata[4:0], 5'h10);
        chk("R5 run cleared", {15'b0, run_stop}, 16'h0);
        clear_all();
        err_parity = 1; step(); err_parity = 0;
        chk("R5 parity", {11'b0, sts_rdata[4:0]}, 16'h10);
        clear_all();
        err_tabort = 1; step(); err_tabort = 0;
        chk("R5 target abort", {11'b0, sts_rdata[4:0]}, 16'h10);
        clear_all();
    endtask

    task automatic t_doorbell_R4();
        async_adv = 1; step(); async_adv = 0;
        chk("R4 advance without doorbell", {15'b0, sts_rdata[5]}, 16'h0);
        doorbell_ring = 1; step(); doorbell_ring = 0;
        chk("R4 pending", {15'b0, doorbell_pend}, 16'h1);
        chk("R4 not yet set", {15'b0, sts_rdata[5]}, 16'h0);
        async_adv = 1; step(); async_adv = 0;
        chk("R4 bit5 set", {15'b0, sts_rdata[5]}, 16'h1);
        chk("R4 doorbell consumed", {15'b0, doorbell_pend}, 16'h0);
        clear_all();
    endtask

    task automatic t_wrap_R6();
        fl_size = 2'd0;
        frindex = 14'h1000; step();
        chk("R6 bit12 ignored at size 1024", {15'b0, sts_rdata[3]}, 16'h0);
        frindex = 14'h3000; step();
        chk("R6 bit13 toggle at size 1024", {15'b0, sts_rdata[3]}, 16'h1);
        clear_all();
        fl_size = 2'd1;
        frindex = 14'h2000; step();
        chk("R6 bit12 toggle at size 512", {15'b0, sts_rdata[3]}, 16'h1);
        clear_all();
        fl_size = 2'd2;
        frindex = 14'h2800; step();
        chk("R6 bit11 toggle at size 256", {15'b0, sts_rdata[3]}, 16'h1);
        clear_all();
        frindex = 14'h0000; step();
        clear_all();
        fl_size = 2'd3;
        frindex = 14'h3000; step();
        chk("R6 bits 13/12 ignored at code 3", {15'b0, sts_rdata[3]}, 16'h0);
        frindex = 14'h3800; step();
        chk("R6 bit11 toggle at code 3", {15'b0, sts_rdata[3]}, 16'h1);
        clear_all();
    endtask

    task automatic t_port_R7();
        port_owner = 4'b0100; port_chg = 4'b0100; step(); port_chg = 0;
        chk("R7 owned port ignored", {15'b0, sts_rdata[2]}, 16'h0);
        port_chg = 4'b0010; step(); port_chg = 0;
        chk("R7 unowned port change", {15'b0, sts_rdata[2]}, 16'h1);
        clear_all();
        force_resume = 4'b1000; step();
        chk("R7 force resume rise", {15'b0, sts_rdata[2]}, 16'h1);
        clear_all();
        chk("R7 held resume level no re-set", {15'b0, sts_rdata[2]}, 16'h0);
        force_resume = 0; port_owner = 0; step();
    endtask

    task automatic t_td_R8_R9();
        td_done = 1; td_err = 1; step(); td_done = 0; td_err = 0;
        chk("R8 error only", {14'b0, sts_rdata[1:0]}, 16'h2);
        clear_all();
        td_done = 1; td_err = 1; td_ioc = 1; step(); td_done = 0; td_err = 0; td_ioc = 0;
        chk("R8 error with ioc sets both", {14'b0, sts_rdata[1:0]}, 16'h3);
        clear_all();
        td_ioc = 1; step(); td_ioc = 0;
        chk("R9 ioc without completion", {14'b0, sts_rdata[1:0]}, 16'h0);
        td_done = 1; td_ioc = 1; step(); td_done = 0; td_ioc = 0;
        chk("R9 completion with ioc", {14'b0, sts_rdata[1:0]}, 16'h1);
        clear_all();
        short_pkt = 1; step(); short_pkt = 0;
        chk("R9 short packet", {14'b0, sts_rdata[1:0]}, 16'h1);
        clear_all();
    endtask

    task automatic t_w1c_R10_R11_R2();
        short_pkt = 1; td_done = 1; td_err = 1; step();
        short_pkt = 0; td_done = 0; td_err = 0;
        sts_wr = 1; sts_wdata = 16'hF000; step(); sts_wr = 0;
        chk("R10 zero writes keep bits and halt", sts_rdata, 16'h1003);
        sts_wr = 1; sts_wdata = 16'h0001; step(); sts_wr = 0;
        chk("R10 clear bit0 only", sts_rdata, 16'h1002);
        short_pkt = 1; sts_wr = 1; sts_wdata = 16'h0003; step();
        short_pkt = 0; sts_wr = 0;
        chk("R11 set beats clear", sts_rdata, 16'h1001);
        clear_all();
        chk("R2 unused bits zero", sts_rdata & 16'hEFC0, 16'h0);
    endtask

    task automatic t_irq_R12();
        intr_en = 6'h01;
        td_done = 1; td_err = 1; step(); td_done = 0; td_err = 0;
        step();
        chk("R12 disabled flag no irq", {15'b0, irq}, 16'h0);
        short_pkt = 1; step(); short_pkt = 0;
        chk("R12 status set, irq not yet", {15'b0, irq}, 16'h0);
        step();
        chk("R12 irq one edge later", {15'b0, irq}, 16'h1);
        sts_wr = 1; sts_wdata = 16'h0001; step(); sts_wr = 0;
        chk("R12 irq still high after clear edge", {15'b0, irq}, 16'h1);
        step();
        chk("R12 irq drops", {15'b0, irq}, 16'h0);
        intr_en = 0;
        clear_all();
    endtask

    initial begin
        @(negedge clk);
        t_reset_R1();
        t_halt_R3();
        t_hse_R5();
        t_doorbell_R4();
        t_wrap_R6();
        t_port_R7();
        t_td_R8_R9();
        t_w1c_R10_R11_R2();
        t_irq_R12();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule